// File: doc/BRIEF.md
# USART Baud and Sampling Clock Generator

This block produces the timing enables for a serial port. It picks one of three clock sources: the system clock, the system clock after a fixed prescaler, or an external serial clock pin. It divides that source by a 16-bit integer divisor. In asynchronous mode it also adds a fractional correction in eighths and then applies an oversampling divider. Every output is a single-cycle enable in the system clock domain. Because no derived clock is ever multiplexed, changing the source selection cannot produce a runt pulse.

In synchronous mode the oversampling divider is bypassed and the block drives a serial clock output. With an internal source that output has a period of `cd` source ticks. When the undivided system clock is the source, a half-cycle correction register keeps the output at 50:50 duty even for odd divisors. When the external pin is selected in synchronous mode, the pin itself becomes the timing reference and the divisor plays no part. The pin must run at least 4.5 times slower than the system clock, because the block synchronises it and detects its rising edges.

Top module: `usart_baud_gen`

## Requirements
- R1: `clk_sel` chooses the source tick. Code 0 ticks every system cycle. Code 1 ticks once every PRESCALE cycles, on the last cycle of each prescaler count that starts at reset. Code 3 ticks on a rising edge of `ext_clk_pin`, seen two cycles after the edge on which the pin is first sampled high. Code 2 never ticks.
- R2: With an internal divisor, a divider tick occurs on every `cd`-th source tick. The first divider tick comes on the first source tick after reset, and again on the first source tick after `cd` leaves 0.
- R3: `cd` = 0 stops all ticks, except in external synchronous mode. `cd` = 1 gives a divider tick on every source tick when `fp` is 0.
- R4: In asynchronous mode a 3-bit accumulator adds `fp` on each divider tick. When that sum reaches 8 or more, the next divider period is `cd`+1 source ticks instead of `cd`. Over time this gives a division of `cd` + `fp`/8.
- R5: In asynchronous mode `samp_en` pulses on each divider tick. `baud_en` pulses on every 16th of those pulses when `over` is 0, and on every 8th when `over` is 1.
- R6: In synchronous mode with an internal source, `samp_en` and `baud_en` both equal the divider tick. `fp` is ignored and there is no oversampling.
- R7: In synchronous mode with `clk_sel` = 3, `samp_en` and `baud_en` pulse on each synchronised pin rising edge. `cd` and `fp` have no effect. `sck_out` follows the pin two cycles late.
- R8: In synchronous mode with `clk_sel` = 0 and `cd` ≥ 2, `sck_out` is high for exactly half of each period, odd `cd` included.
- R9: In synchronous mode with `clk_sel` = 1 and an even `cd`, `sck_out` has 50:50 duty. With an internal source and `cd` < 2, `sck_out` stays low.
- R10: In asynchronous mode `sck_out` stays low.
- R11: When `clk_sel`, `sync_mode` or `cd` changes while the block is running, enables come only from the newly selected path, with no extra or merged pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_pin | input | 1 | External serial clock pin, asynchronous to `clk` |
| clk_sel | input | 2 | Source select: 0 system, 1 prescaled, 2 reserved, 3 pin |
| cd | input | CD_W | Integer divisor |
| fp | input | FP_W | Fractional correction in eighths |
| over | input | 1 | 0: oversample by 16, 1: oversample by 8 |
| sync_mode | input | 1 | 1 selects synchronous mode |
| samp_en | output | 1 | Sampling-clock enable, one cycle wide |
| baud_en | output | 1 | Baud-clock enable, one cycle wide |
| sck_out | output | 1 | Serial clock output |

## Verification
Internal state shows up at the ports in three ways:
- A wrong divider count or accumulator value moves the next `samp_en` pulse by at least one source tick.
- A wrong oversampling count shifts `baud_en` relative to `samp_en` within one baud period.
- A slip in pin synchronisation changes both the timing of the enables and `sck_out` within two system cycles.

A behavioural model predicts every enable on every cycle, through source switches and divisor changes. Duty cycle is measured from two samples per system cycle over whole periods, so a missing half-cycle correction shows within a single window.

// File: rtl/usart_baud_gen.sv
module usart_baud_gen #(
  parameter int CD_W     = 16,
  parameter int FP_W     = 3,
  parameter int PRESCALE = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ext_clk_pin,
  input  logic [1:0]      clk_sel,
  input  logic [CD_W-1:0] cd,
  input  logic [FP_W-1:0] fp,
  input  logic            over,
  input  logic            sync_mode,
  output logic            samp_en,
  output logic            baud_en,
  output logic            sck_out
);
  localparam int PRE_W = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [2:0]       pin_sy;
  logic [PRE_W-1:0] pre_cnt;
  logic [CD_W-1:0]  cnt;
  logic [FP_W-1:0]  acc;
  logic [3:0]       os_cnt;
  logic             sck_pos, sck_neg;

  wire ext_tick = pin_sy[1] & ~pin_sy[2];
  wire pre_tick = (pre_cnt == PRE_LAST);
  wire ext_mode = sync_mode && (clk_sel == 2'd3);
  wire run      = (cd != '0) && !ext_mode;

  logic src_tick;
  always_comb begin
    case (clk_sel)
      2'd0:    src_tick = 1'b1;
      2'd1:    src_tick = pre_tick;
      2'd3:    src_tick = ext_tick;
      default: src_tick = 1'b0;
    endcase
  end

  wire [FP_W:0] acc_sum = {1'b0, acc} + {1'b0, fp};
  wire add_one  = acc_sum[FP_W] && !sync_mode;
  wire div_tick = run && src_tick && (cnt == '0);
  wire [3:0] os_top = over ? 4'd7 : 4'd15;
  wire os_last  = (os_cnt >= os_top);
  wire sck_hi   = (cd > CD_W'(1)) && (cnt >= (cd >> 1));
  wire half_fix = (clk_sel == 2'd0) && cd[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_sy  <= '0;
      pre_cnt <= '0;
    end else begin
      pin_sy  <= {pin_sy[1:0], ext_clk_pin};
      pre_cnt <= pre_tick ? '0 : pre_cnt + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      acc <= '0;
    end else if (!run) begin
      cnt <= '0;
      acc <= '0;
    end else if (src_tick) begin
      if (cnt == '0) begin
        cnt <= cd - CD_W'(1) + CD_W'(add_one);
        if (!sync_mode) acc <= acc_sum[FP_W-1:0];
      end else begin
        cnt <= cnt - CD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          os_cnt <= '0;
    else if (sync_mode)  os_cnt <= '0;
    else if (div_tick)   os_cnt <= os_last ? 4'd0 : os_cnt + 4'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_pos <= 1'b0;
    else        sck_pos <= sync_mode && !ext_mode && sck_hi;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) sck_neg <= 1'b0;
    else        sck_neg <= sck_pos;
  end

  assign samp_en = ext_mode ? ext_tick : div_tick;
  assign baud_en = ext_mode ? ext_tick : (div_tick && (sync_mode || os_last));
  assign sck_out = ext_mode ? pin_sy[1] : (half_fix ? (sck_pos & sck_neg) : sck_pos);

  a_r1_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd2) |-> !samp_en);
  a_r5_baud_within_samp: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |-> samp_en);
  a_r2_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_en && !ext_mode && (cd > CD_W'(1))) |=> (ext_mode || !samp_en));
  a_r6_sync_same_enables: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (baud_en == samp_en));
  a_r7_pin_high_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && samp_en) |-> sck_out);
  a_r10_async_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !sck_out);
endmodule

// File: tb/usart_baud_gen_tb.sv
module usart_baud_gen_tb_top;
  localparam int CLK_P = 10;
  localparam int PRE   = 8;

  logic clk = 0, rst_n = 0, pin = 0;
  logic [1:0] sel = 0;
  logic [15:0] cd = 0;
  logic [2:0] fp = 0;
  logic over = 0, sync_m = 0;
  logic samp_en, baud_en, sck_out;

  usart_baud_gen #(.CD_W(16), .FP_W(3), .PRESCALE(PRE)) dut_i (
    .clk(clk), .rst_n(rst_n), .ext_clk_pin(pin), .clk_sel(sel), .cd(cd), .fp(fp),
    .over(over), .sync_mode(sync_m), .samp_en(samp_en), .baud_en(baud_en), .sck_out(sck_out));

  always #(CLK_P/2) clk = ~clk;

  int errors = 0, checks = 0;
  string cur_req = "R2";
  bit chk_on = 0, meas_on = 0;
  int hi_cnt = 0, pin_half = 0, pin_pc = 0;

  int m_c = 0, m_rem = 0, m_acc = 0, m_os = 0;
  bit p1 = 0, p2 = 0, p3 = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp_v, input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s at %0t: actual=%0d expected=%0d", req, what, $time, act, exp_v);
    end
  endtask

  function automatic bit m_src();
    case (sel)
      2'd0: return 1'b1;
      2'd1: return (m_c % PRE) == PRE - 1;
      2'd3: return p2 && !p3;
      default: return 1'b0;
    endcase
  endfunction

  function automatic bit m_ext(); return sync_m && sel == 2'd3; endfunction
  function automatic bit m_div(); return (cd != 0) && !m_ext() && m_src() && m_rem == 0; endfunction
  function automatic int m_lim(); return over ? 8 : 16; endfunction

  always @(posedge clk) if (rst_n) begin
    bit s, d;
    s = m_src(); d = m_div();
    if (cd == 0 || m_ext()) begin m_rem = 0; m_acc = 0; end
    else if (s) begin
      if (m_rem == 0) begin
        int extra;
        extra = (!sync_m && (m_acc + fp >= 8)) ? 1 : 0;
        m_rem = cd - 1 + extra;
        if (!sync_m) m_acc = (m_acc + fp) % 8;
      end else m_rem--;
    end
    if (sync_m) m_os = 0;
    else if (d) m_os = (m_os >= m_lim() - 1) ? 0 : m_os + 1;
    m_c++;
    p3 = p2; p2 = p1; p1 = pin;
  end

  always @(negedge clk) if (chk_on) begin
    bit es, eb;
    if (m_ext()) begin es = p2 && !p3; eb = es; end
    else begin es = m_div(); eb = es && (sync_m || m_os >= m_lim() - 1); end
    check(samp_en == es, cur_req, samp_en, es, "samp_en");
    check(baud_en == eb, (sync_m || eb == es) ? cur_req : "R5", baud_en, eb, "baud_en");
    if (m_ext()) check(sck_out == p2, "R7", sck_out, p2, "sck_out follows pin");
    else if (!sync_m) check(sck_out == 1'b0, "R10", sck_out, 0, "sck_out in async");
  end

  always @(negedge clk) if (pin_half != 0) begin
    pin_pc++;
    if (pin_pc >= pin_half) begin pin_pc = 0; pin = ~pin; end
  end

  always @(posedge clk) begin #2; if (meas_on) hi_cnt += sck_out; end
  always @(negedge clk) begin #2; if (meas_on) hi_cnt += sck_out; end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic measure(input int cyc, input int exp_hi, input string req);
    hi_cnt = 0; meas_on = 1;
    run(cyc);
    meas_on = 0;
    check(hi_cnt == exp_hi, req, hi_cnt, exp_hi, "sck_out high half-cycles");
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run(3);
    check(samp_en == 0 && baud_en == 0 && sck_out == 0, "R3", {samp_en, baud_en, sck_out}, 0, "reset state");
    rst_n = 1; chk_on = 1;
    cur_req = "R2"; sel = 0; cd = 4; run(300);
    cur_req = "R4"; cd = 5; fp = 3; over = 1; run(400);
    cur_req = "R5"; fp = 0; cd = 3; over = 0; run(200);
    cur_req = "R1"; sel = 1; cd = 3; fp = 5; run(600);
    cur_req = "R3"; sel = 0; fp = 0; cd = 1; run(100);
    cd = 0; run(50);
    cur_req = "R1"; sel = 2; cd = 2; run(50);
    cur_req = "R1"; pin_half = 5; sel = 3; run(300);
    cur_req = "R11"; sel = 0; cd = 3; run(20); sel = 1; run(30); sync_m = 1; run(30); sel = 3; run(40);
    cd = 2; sync_m = 0; run(40);
    cur_req = "R6"; sync_m = 1; sel = 0; fp = 6; cd = 4; run(20);
    measure(4 * 10, 4 * 10, "R8");
    cd = 5; run(20); measure(5 * 10, 5 * 10, "R8");
    cd = 7; run(20); measure(7 * 6, 7 * 6, "R8");
    cd = 1; run(20); measure(30, 0, "R9");
    sel = 1; cd = 4; run(80); measure(4 * PRE * 4, 4 * PRE * 4, "R9");
    cur_req = "R7"; sel = 3; cd = 0; fp = 7; pin_half = 6; run(300);
    cd = 9; run(200);
    cur_req = "R10"; sync_m = 0; sel = 0; cd = 2; run(100);
    chk_on = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule